// File: doc/BRIEF.md
# Producer-Consumer Latency Scoreboard

This block sits beside an in-order issue stage and tells it, every cycle, whether the value named by a source tag can be consumed yet. Each time an operation issues, the stage writes the destination tag and a producer class into the scoreboard. Each tag then holds a small per-tag state machine that counts the cycles since that write. A query names a source tag and a consumer class. The block answers with a combinational ready bit. The issue stage stalls the consumer while that bit is low.

The answer depends on both sides of the dependency. Most producers have one fixed result latency. Certain producer/consumer pairings use a different latency, which can be shorter (forwarding between like units) or longer (condition results that are produced late). Each entry therefore keeps the producer class and its age, not a plain countdown. Latency is resolved when the query arrives. Two query ports work in parallel, one for each source operand.

Each tag entry has two states. `EN_IDLE` means no producer is outstanding. `EN_PEND` means a producer is in flight. The transition IDLE→PEND happens on an issue to that tag. PEND→PEND happens on each cycle of ageing, and also on a re-issue, which restarts the age at 1. PEND→IDLE happens once the age has reached the largest latency (14) and no issue hits the tag in that cycle.

Top module: `lsb_scoreboard`

## Requirements
- R1: Right after reset no tag is pending, and every query port reads ready for every tag and class.
- R2: Producer class codes on `iss_class` and their latencies toward a generic consumer: 0 simple ALU = 2, 1 multiply = 5, 2 record-form multiply = 5, 3 divide = 12, 4 record-form divide = 12, 5 matrix op = 9, 6 store = 0, 7 store-with-update = 2, 8 double-precision load = 4, 9 single-precision load = 7. Consumer class codes on `qry_class`: 0 generic, 1 condition-register consumer, 2 multiply, 3 matrix op.
- R3: A simple ALU producer (0) queried by a condition-register consumer (1) needs 4 cycles.
- R4: A multiply or record-form multiply producer (1 or 2) queried by a multiply consumer (2) needs 4 cycles.
- R5: A condition-register consumer (1) needs 7 cycles after a record-form multiply (2) and 14 cycles after a record-form divide (4).
- R6: A matrix producer (5) queried by a matrix consumer (3) needs 4 cycles.
- R7: An issue sampled at the clock edge that ends cycle c gives age k in cycle c+k. The query reads ready when the age is at least the latency of the pair. A query made in cycle c itself sees the state from before the issue.
- R8: An issue to a tag that is still pending replaces the class and restarts the age, so the youngest producer decides readiness.
- R9: A tag with no pending producer reads ready. An entry retires after its age has reached 14.
- R10: Reserved producer codes 10 to 15 use a latency of 14 for every consumer.
- R11: The query ports are independent. Two ports that name the same tag and class give the same answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A producer issues this cycle |
| iss_tag | input | TAG_W | Destination tag of the issuing producer |
| iss_class | input | 4 | Producer class code (R2) |
| qry_tag | input | NUM_SRC*TAG_W | Source tags, port p in bits [p*TAG_W +: TAG_W] |
| qry_class | input | NUM_SRC*2 | Consumer class codes, port p in bits [p*2 +: 2] |
| qry_ready | output | NUM_SRC | Ready answer for each query port in the current cycle |

## Verification
The hardest situations to reach from the ports are the exact boundary cycles of the long override pairs, such as the 13th and 14th cycles after a record-form divide seen by a condition consumer. The same holds for a re-issue that lands while an older producer still has cycles to run. Directed sequences issue each class once and then hold queries on that tag, with several consumer classes on both ports, for every cycle until the entry retires. A random phase confines most issues and queries to four tags, so that overwrites and mid-flight queries happen often. A reference model in the bench tracks age per tag and gives the expected ready bit for every cycle.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    localparam int PCLS_W = 4;
    localparam int CCLS_W = 2;

    // base latencies per producer class
    localparam int LAT_ALU     = 2;
    localparam int LAT_MUL     = 5;
    localparam int LAT_DIV     = 12;
    localparam int LAT_MMA     = 9;
    localparam int LAT_STORE   = 0;
    localparam int LAT_STUPD   = 2;
    localparam int LAT_LDDP    = 4;
    localparam int LAT_LDSP    = 7;

    // pairwise overrides
    localparam int OVR_ALU_CR    = 4;
    localparam int OVR_MUL_MUL   = 4;
    localparam int OVR_MULREC_CR = 7;
    localparam int OVR_DIVREC_CR = 14;
    localparam int OVR_MMA_MMA   = 4;

    // the largest latency any pair can need; ages saturate here
    localparam int LAT_MAX = 14;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    typedef enum logic [PCLS_W-1:0] {
        PC_ALU    = 4'd0,
        PC_MUL    = 4'd1,
        PC_MULREC = 4'd2,
        PC_DIV    = 4'd3,
        PC_DIVREC = 4'd4,
        PC_MMA    = 4'd5,
        PC_STORE  = 4'd6,
        PC_STUPD  = 4'd7,
        PC_LDDP   = 4'd8,
        PC_LDSP   = 4'd9
    } pcls_e;

    typedef enum logic [CCLS_W-1:0] {
        CC_GEN = 2'd0,
        CC_CR  = 2'd1,
        CC_MUL = 2'd2,
        CC_MMA = 2'd3
    } ccls_e;

    typedef enum logic {
        EN_IDLE = 1'b0,
        EN_PEND = 1'b1
    } ent_state_e;

endpackage

// File: rtl/lsb_lat_sel.sv
module lsb_lat_sel
    import lsb_pkg::*;
(
    input  logic [PCLS_W-1:0] pcls,
    input  logic [CCLS_W-1:0] ccls,
    output logic [CNT_W-1:0]  lat
);

    int base_lat;
    int pair_lat;

    // latency of the producer alone
    always_comb begin
        unique case (pcls)
            PC_ALU:    base_lat = LAT_ALU;
            PC_MUL:    base_lat = LAT_MUL;
            PC_MULREC: base_lat = LAT_MUL;
            PC_DIV:    base_lat = LAT_DIV;
            PC_DIVREC: base_lat = LAT_DIV;
            PC_MMA:    base_lat = LAT_MMA;
            PC_STORE:  base_lat = LAT_STORE;
            PC_STUPD:  base_lat = LAT_STUPD;
            PC_LDDP:   base_lat = LAT_LDDP;
            PC_LDSP:   base_lat = LAT_LDSP;
            default:   base_lat = LAT_MAX;
        endcase
    end

    // pairwise override, falls back to the base value
    always_comb begin
        pair_lat = base_lat;
        if (pcls == PC_ALU && ccls == CC_CR)
            pair_lat = OVR_ALU_CR;
        else if ((pcls == PC_MUL || pcls == PC_MULREC) && ccls == CC_MUL)
            pair_lat = OVR_MUL_MUL;
        else if (pcls == PC_MULREC && ccls == CC_CR)
            pair_lat = OVR_MULREC_CR;
        else if (pcls == PC_DIVREC && ccls == CC_CR)
            pair_lat = OVR_DIVREC_CR;
        else if (pcls == PC_MMA && ccls == CC_MMA)
            pair_lat = OVR_MMA_MMA;
    end

    assign lat = CNT_W'(pair_lat);

endmodule

// File: rtl/lsb_entry.sv
module lsb_entry
    import lsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PCLS_W-1:0] wr_cls,
    output logic              pend,
    output logic [PCLS_W-1:0] cls,
    output logic [CNT_W-1:0]  age
);

    ent_state_e          state_q, state_d;
    logic [PCLS_W-1:0]   cls_q, cls_d;
    logic [CNT_W-1:0]    age_q, age_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            cls_q   <= '0;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            cls_q   <= cls_d;
            age_q   <= age_d;
        end
    end

    // next state: a write always wins and restarts the age at one
    always_comb begin
        state_d = state_q;
        cls_d   = cls_q;
        age_d   = age_q;
        unique case (state_q)
            EN_IDLE: begin
                if (wr) begin
                    state_d = EN_PEND;
                    cls_d   = wr_cls;
                    age_d   = CNT_W'(1);
                end
            end
            EN_PEND: begin
                if (wr) begin
                    cls_d = wr_cls;
                    age_d = CNT_W'(1);
                end else if (age_q >= CNT_W'(LAT_MAX)) begin
                    state_d = EN_IDLE;
                    age_d   = '0;
                end else begin
                    age_d = age_q + CNT_W'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        pend = (state_q == EN_PEND);
        cls  = cls_q;
        age  = age_q;
    end

endmodule

// File: rtl/lsb_query.sv
module lsb_query
    import lsb_pkg::*;
#(
    parameter int TAG_W    = 5,
    parameter int NUM_TAGS = 1 << TAG_W
) (
    input  logic [NUM_TAGS-1:0]             pend_vec,
    input  logic [NUM_TAGS-1:0][PCLS_W-1:0] cls_arr,
    input  logic [NUM_TAGS-1:0][CNT_W-1:0]  age_arr,
    input  logic [TAG_W-1:0]                tag,
    input  logic [CCLS_W-1:0]               ccls,
    output logic                            ready
);

    logic [PCLS_W-1:0] sel_cls;
    logic [CNT_W-1:0]  sel_age;
    logic              sel_pend;
    logic [CNT_W-1:0]  need;

    always_comb begin
        sel_pend = pend_vec[tag];
        sel_cls  = cls_arr[tag];
        sel_age  = age_arr[tag];
    end

    lsb_lat_sel u_lat (
        .pcls (sel_cls),
        .ccls (ccls),
        .lat  (need)
    );

    assign ready = !sel_pend || (sel_age >= need);

endmodule

// File: rtl/lsb_scoreboard.sv
module lsb_scoreboard
    import lsb_pkg::*;
#(
    parameter int TAG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic [TAG_W-1:0]           iss_tag,
    input  logic [3:0]                 iss_class,
    input  logic [NUM_SRC*TAG_W-1:0]   qry_tag,
    input  logic [NUM_SRC*2-1:0]       qry_class,
    output logic [NUM_SRC-1:0]         qry_ready
);

    localparam int NUM_TAGS = 1 << TAG_W;

    logic [NUM_TAGS-1:0]             pend_vec;
    logic [NUM_TAGS-1:0][PCLS_W-1:0] cls_arr;
    logic [NUM_TAGS-1:0][CNT_W-1:0]  age_arr;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_ent
        logic hit;
        assign hit = iss_valid && (iss_tag == TAG_W'(t));
        lsb_entry u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (hit),
            .wr_cls (iss_class),
            .pend   (pend_vec[t]),
            .cls    (cls_arr[t]),
            .age    (age_arr[t])
        );
    end

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        lsb_query #(
            .TAG_W    (TAG_W),
            .NUM_TAGS (NUM_TAGS)
        ) u_qry (
            .pend_vec (pend_vec),
            .cls_arr  (cls_arr),
            .age_arr  (age_arr),
            .tag      (qry_tag[p*TAG_W +: TAG_W]),
            .ccls     (qry_class[p*CCLS_W +: CCLS_W]),
            .ready    (qry_ready[p])
        );
    end

endmodule

// File: rtl/lsb_scoreboard_chk.sv
module lsb_scoreboard_chk #(
    parameter int TAG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    input  logic [TAG_W-1:0]         iss_tag,
    input  logic [3:0]               iss_class,
    input  logic [NUM_SRC*TAG_W-1:0] qry_tag,
    input  logic [NUM_SRC*2-1:0]     qry_class,
    input  logic [NUM_SRC-1:0]       qry_ready
);

    logic       first_q;
    logic [1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            since_q <= '0;
        end else begin
            first_q <= 1'b0;
            if (since_q != 2'd3) since_q <= since_q + 2'd1;
        end
    end

    // R1
    reset_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (&qry_ready));

    // R7
    next_cycle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class != 4'd6) |=>
        ((qry_tag[TAG_W-1:0] != $past(iss_tag)) || !qry_ready[0]));

    // R2
    store_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 4'd6) |=>
        ((qry_tag[TAG_W-1:0] != $past(iss_tag)) || qry_ready[0]));

    // R2
    alu_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_q >= 2'd2) && $past(iss_valid, 2) && ($past(iss_class, 2) == 4'd0)
         && !($past(iss_valid) && ($past(iss_tag) == $past(iss_tag, 2)))
         && (qry_tag[TAG_W-1:0] == $past(iss_tag, 2)) && (qry_class[1:0] == 2'd0))
        |-> qry_ready[0]);

    if (NUM_SRC > 1) begin : g_pair
        // R11
        port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((qry_tag[TAG_W-1:0] == qry_tag[2*TAG_W-1:TAG_W]) &&
             (qry_class[1:0] == qry_class[3:2]))
            |-> (qry_ready[0] == qry_ready[1]));
    end

endmodule

bind lsb_scoreboard lsb_scoreboard_chk #(
    .TAG_W   (TAG_W),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_tag   (iss_tag),
    .iss_class (iss_class),
    .qry_tag   (qry_tag),
    .qry_class (qry_class),
    .qry_ready (qry_ready)
);

// File: tb/lsb_scoreboard_bench.sv
module lsb_scoreboard_bench;

    localparam int TAG_W = 5;
    localparam int NT    = 1 << TAG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [TAG_W-1:0] iss_tag = '0;
    logic [3:0]       iss_class = '0;
    logic [2*TAG_W-1:0] qry_tag = '0;
    logic [3:0]       qry_class = '0;
    logic [1:0]       qry_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_pend [NT];
    int m_age  [NT];
    int m_cls  [NT];

    always #10 clk = ~clk;

    lsb_scoreboard #(.TAG_W(TAG_W), .NUM_SRC(2)) u_lsb_scoreboard (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_tag   (iss_tag),
        .iss_class (iss_class),
        .qry_tag   (qry_tag),
        .qry_class (qry_class),
        .qry_ready (qry_ready)
    );

    function automatic int exp_lat(int p, int c);
        case (p)
            0: return (c == 1) ? 4 : 2;
            1: return (c == 2) ? 4 : 5;
            2: return (c == 2) ? 4 : ((c == 1) ? 7 : 5);
            3: return 12;
            4: return (c == 1) ? 14 : 12;
            5: return (c == 3) ? 4 : 9;
            6: return 0;
            7: return 2;
            8: return 4;
            9: return 7;
            default: return 14;
        endcase
    endfunction

    function automatic string req_of(int t, int c);
        int p = m_cls[t];
        if (m_pend[t] == 0) return "R9";
        if (p >= 10) return "R10";
        if (p == 0 && c == 1) return "R3";
        if ((p == 1 || p == 2) && c == 2) return "R4";
        if ((p == 2 || p == 4) && c == 1) return "R5";
        if (p == 5 && c == 3) return "R6";
        return "R2";
    endfunction

    function automatic bit exp_ready(int t, int c);
        if (m_pend[t] == 0) return 1'b1;
        return m_age[t] >= exp_lat(m_cls[t], c);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NT; i++) begin
            m_pend[i] = 0; m_age[i] = 0; m_cls[i] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iss_valid = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one cycle: drive at negedge, check mid-cycle, update model at posedge
    task automatic step(bit iv, int it, int ic, int t0, int c0, int t1, int c1, string lbl);
        bit e0, e1;
        string r0, r1;
        @(negedge clk);
        iss_valid = iv;
        iss_tag   = TAG_W'(it);
        iss_class = 4'(ic);
        qry_tag   = {TAG_W'(t1), TAG_W'(t0)};
        qry_class = {2'(c1), 2'(c0)};
        #1;
        e0 = exp_ready(t0, c0);
        e1 = exp_ready(t1, c1);
        r0 = (lbl == "") ? req_of(t0, c0) : lbl;
        r1 = (lbl == "") ? req_of(t1, c1) : lbl;
        n_cmp += 2;
        if (qry_ready[0] !== e0) begin
            n_bad++;
            $display("FAIL %s port0 tag %0d cls %0d: actual %b expected %b", r0, t0, c0, qry_ready[0], e0);
        end
        if (qry_ready[1] !== e1) begin
            n_bad++;
            $display("FAIL %s port1 tag %0d cls %0d: actual %b expected %b", r1, t1, c1, qry_ready[1], e1);
        end
        @(posedge clk);
        for (int i = 0; i < NT; i++) begin
            if (m_pend[i] != 0) begin
                if (m_age[i] >= 14) begin m_pend[i] = 0; m_age[i] = 0; end
                else m_age[i]++;
            end
        end
        if (iv) begin
            m_pend[it] = 1; m_age[it] = 1; m_cls[it] = ic;
        end
    endtask

    task automatic idle(int n, int t0, int c0, int t1, int c1, string lbl);
        for (int k = 0; k < n; k++) step(0, 0, 0, t0, c0, t1, c1, lbl);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_clear();
        do_reset();

        // R1: every tag ready right after reset
        for (int t = 0; t < NT; t++) step(0, 0, 0, t, t % 4, NT - 1 - t, (t + 1) % 4, "R1");

        // R7: query in the issue cycle sees the old state; then ALU vs CR/GEN
        step(1, 3, 0, 3, 1, 3, 0, "R7");
        idle(5, 3, 1, 3, 0, "");

        // R11: same tag, two consumer classes on the two ports
        step(1, 2, 0, 2, 0, 2, 1, "R11");
        idle(5, 2, 0, 2, 1, "R11");

        // R4, R5: record multiply seen by CR and MUL consumers
        step(1, 4, 2, 0, 0, 0, 0, "");
        idle(16, 4, 1, 4, 2, "");
        step(1, 4, 1, 0, 0, 0, 0, "");
        idle(6, 4, 2, 4, 1, "");

        // R5: record divide seen by a CR consumer up to the 14 boundary
        step(1, 5, 4, 0, 0, 0, 0, "");
        idle(16, 5, 1, 5, 0, "");

        // R6: matrix producer
        step(1, 6, 5, 0, 0, 0, 0, "");
        idle(11, 6, 3, 6, 0, "");

        // R8: younger store replaces a divide in flight
        step(1, 7, 3, 0, 0, 0, 0, "");
        idle(3, 7, 0, 7, 1, "");
        step(1, 7, 6, 7, 0, 7, 0, "R8");
        idle(2, 7, 0, 7, 1, "R8");
        // R8: younger ALU replaces a multiply
        step(1, 12, 1, 0, 0, 0, 0, "");
        idle(2, 12, 0, 12, 2, "");
        step(1, 12, 0, 12, 0, 12, 0, "R8");
        idle(3, 12, 0, 12, 1, "R8");

        // R10: reserved producer codes
        step(1, 8, 12, 0, 0, 0, 0, "");
        idle(16, 8, 0, 8, 3, "R10");
        step(1, 8, 15, 0, 0, 0, 0, "");
        idle(15, 8, 1, 8, 2, "R10");

        // R2: loads and store-with-update
        step(1, 9, 9, 0, 0, 0, 0, "");
        step(1, 10, 8, 9, 0, 9, 1, "R2");
        step(1, 11, 7, 9, 0, 10, 0, "R2");
        idle(8, 9, 0, 10, 0, "R2");
        idle(3, 11, 0, 11, 1, "R2");

        // R9: everything retired after a long quiet stretch
        idle(16, 0, 0, 0, 0, "");
        for (int t = 0; t < NT; t++) step(0, 0, 0, t, 1, t, 2, "R9");

        // random phase, mostly on four tags to force overwrites
        for (int k = 0; k < 3000; k++) begin
            bit iv = ($urandom % 3) != 0;
            int it = (($urandom % 4) != 0) ? int'($urandom % 4) : int'($urandom % NT);
            int ic = (($urandom % 8) != 0) ? int'($urandom % 10) : int'($urandom % 16);
            int t0 = (($urandom % 4) != 0) ? int'($urandom % 4) : int'($urandom % NT);
            int t1 = (($urandom % 4) != 0) ? int'($urandom % 4) : int'($urandom % NT);
            step(iv, it, ic, t0, int'($urandom % 4), t1, int'($urandom % 4), "");
        end

        // reset in mid flight clears pending entries (R1)
        step(1, 1, 4, 0, 0, 0, 0, "");
        do_reset();
        for (int t = 0; t < 4; t++) step(0, 0, 0, t, 1, t, 0, "R1");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule